// File: doc/BRIEF.md
# Prescaled Compare Up-Counter Timer

This block is an 8-bit up-counter that advances through a selectable prescaler. Each step, the host supplies the number of machine cycles that elapsed since the last step. The prescaler collects these cycles in an accumulator. For every full prescale period the accumulator holds, it gives one count increment and keeps the remainder for later. A single step can therefore advance the counter by many counts. The counter wraps to zero when it reaches a compare value. When a wrap happens, an interrupt request may be raised, depending on a per-source enable, a global enable and, optionally, the current priority level.

The block has a small register port with two registers. The configuration register holds a run bit and a 3-bit prescale select. The limit register takes the compare value on a write. A read of the limit register returns the live count instead of the compare value. A chip would place two copies side by side. One copy is built with priority gating enabled and one without it, chosen by a parameter.

Top module: `pscmp_timer`

## Requirements
- R1: After synchronous reset, the configuration reads 0x00, the count reads 0 and `irq_req` is low.
- R2: A write with `wr_sel`=0 stores the configuration: bit 7 is the run bit and bits 2:0 are the prescale select. A read with `rd_sel`=0 returns those bits in the same positions and 0 in bits 6:3.
- R3: A configuration write clears both the prescale accumulator and the count, so cycles collected before the write never produce an increment.
- R4: A write with `wr_sel`=1 stores the byte as the compare value and clears the count. A read with `rd_sel`=1 returns the live count, not the compare value.
- R5: While the run bit is 0, steps change neither the count nor the accumulator, and no interrupt is requested.
- R6: While running, a step adds `step_cycles` to the accumulator. The prescale period is half of entry `sel` of an 8-entry constant table (default entries 2, 4, 8, …, 256 for select 0 to 7). The count increments once for each whole period, possibly many times in one step, and the remainder carries to later steps.
- R7: After each increment, if the count is greater than or equal to the compare value, it becomes 0 (a wrap). With a compare value of 0, the count stays 0 and every increment is a wrap.
- R8: `irq_req` is high for exactly the one cycle after a step in which at least one wrap occurred, and only if `src_irq_en` and `glob_irq_en` were both high during that step.
- R9: With `PRIO_GATE`=1, the request also needs `prio_level` below `PRIO_CEIL` (default 4) during the step. With `PRIO_GATE`=0, `prio_level` has no effect.
- R10: A register write in the same cycle as a step takes precedence: the step is discarded, so neither the accumulator nor the count advances and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 configuration, 1 compare limit |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 configuration, 1 live count |
| rd_data | output | 8 | Read data, combinational from the registers |
| step_valid | input | 1 | A step is presented this cycle |
| step_cycles | input | 8 | Elapsed machine cycles for this step |
| src_irq_en | input | 1 | Per-source interrupt enable |
| glob_irq_en | input | 1 | Global interrupt enable |
| prio_level | input | 3 | Current priority level |
| irq_req | output | 1 | One-cycle interrupt request after a wrapping step |

## Verification
Writes and steps take effect on the rising edge that samples them. The new count and configuration are visible on `rd_data` right after that edge. `irq_req` is registered, so it is high only during the cycle that follows the step's edge and is low again after the next edge. The bench changes inputs on falling edges and samples every result on the next falling edge, which is the single window in which both the count and the request pulse belong to the step just applied. The sweep covers all eight prescale selects and six compare values with pseudo-random cycle counts, enables and priority levels. A cycle-by-cycle increment loop in the bench computes the expected count and wrap.

// File: rtl/pst_pkg.sv
package pst_pkg;

    localparam int CNT_W  = 8;
    localparam int CYC_W  = 8;
    localparam int ACC_W  = 32;
    localparam int SEL_W  = 3;
    localparam int TBL_N  = 1 << SEL_W;
    localparam int ENT_W  = 16;
    localparam int PRIO_W = 3;

    typedef logic [TBL_N-1:0][ENT_W-1:0] tbl_t;

    // index 0 holds the first (shortest) entry
    localparam tbl_t DEFAULT_TBL = {16'd256, 16'd128, 16'd64, 16'd32,
                                    16'd16,  16'd8,   16'd4,  16'd2};

    typedef enum logic {
        REG_CFG   = 1'b0,
        REG_LIMIT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic             run;
        logic [SEL_W-1:0] sel;
    } cfg_t;

    // prescale period is half the table entry, never below one cycle
    function automatic logic [ACC_W-1:0] half_period(input logic [ENT_W-1:0] ent);
        logic [ACC_W-1:0] p;
        p = ACC_W'(ent >> 1);
        if (p == '0) p = ACC_W'(1);
        return p;
    endfunction

endpackage

// File: rtl/pst_regs.sv
module pst_regs
    import pst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output cfg_t             cfg_q,
    output logic [CNT_W-1:0] limit_q,
    output logic             cfg_wr,
    output logic             limit_wr
);

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^wr_data[6:SEL_W];

    assign cfg_wr   = wr_en && (reg_sel_e'(wr_sel) == REG_CFG);
    assign limit_wr = wr_en && (reg_sel_e'(wr_sel) == REG_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            limit_q <= '0;
        end else begin
            if (cfg_wr) begin
                cfg_q.run <= wr_data[7];
                cfg_q.sel <= wr_data[SEL_W-1:0];
            end
            if (limit_wr) limit_q <= wr_data;
        end
    end

endmodule

// File: rtl/pst_prescale.sv
module pst_prescale
    import pst_pkg::*;
#(
    parameter tbl_t TABLE = DEFAULT_TBL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    input  logic [SEL_W-1:0] sel,
    input  logic [CYC_W-1:0] cycles,
    output logic [ACC_W-1:0] acc_q,
    output logic [ACC_W-1:0] ticks
);

    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] quo [TBL_N];
    logic [ACC_W-1:0] rem [TBL_N];

    assign sum = acc_q + ACC_W'(cycles);

    // one constant divider per table entry; select picks the result
    for (genvar i = 0; i < TBL_N; i++) begin : g_div
        localparam logic [ACC_W-1:0] PERIOD = half_period(TABLE[i]);
        assign quo[i] = sum / PERIOD;
        assign rem[i] = sum % PERIOD;
    end

    assign ticks = advance ? quo[sel] : '0;

    always_ff @(posedge clk) begin
        if (rst || clear) acc_q <= '0;
        else if (advance) acc_q <= rem[sel];
    end

endmodule

// File: rtl/pst_count.sv
module pst_count
    import pst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    input  logic [CNT_W-1:0] limit,
    input  logic [ACC_W-1:0] ticks,
    output logic [CNT_W-1:0] count_q,
    output logic             wrapped
);

    logic [ACC_W:0]   total;
    logic [ACC_W:0]   limit_ext;
    logic [CNT_W-1:0] count_nxt;

    assign total     = (ACC_W+1)'(count_q) + (ACC_W+1)'(ticks);
    assign limit_ext = (ACC_W+1)'(limit);

    always_comb begin
        count_nxt = count_q;
        wrapped   = 1'b0;
        if (advance) begin
            if (limit == '0) begin
                count_nxt = '0;
                wrapped   = (ticks != '0);
            end else begin
                count_nxt = CNT_W'(total % limit_ext);
                wrapped   = (total >= limit_ext);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) count_q <= '0;
        else              count_q <= count_nxt;
    end

endmodule

// File: rtl/pst_irq_gate.sv
module pst_irq_gate
    import pst_pkg::*;
#(
    parameter bit PRIO_GATE = 1'b1,
    parameter int PRIO_CEIL = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrapped,
    input  logic              src_en,
    input  logic              glob_en,
    input  logic [PRIO_W-1:0] prio,
    output logic              irq_q
);

    logic prio_ok;

    if (PRIO_GATE) begin : g_prio
        assign prio_ok = (prio < PRIO_W'(PRIO_CEIL));
    end else begin : g_noprio
        logic unused_prio;
        assign unused_prio = ^prio;
        assign prio_ok     = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= wrapped && src_en && glob_en && prio_ok;
    end

endmodule

// File: rtl/pscmp_timer.sv
module pscmp_timer
    import pst_pkg::*;
#(
    parameter tbl_t TABLE     = DEFAULT_TBL,
    parameter bit   PRIO_GATE = 1'b1,
    parameter int   PRIO_CEIL = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              rd_sel,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              step_valid,
    input  logic [CYC_W-1:0]  step_cycles,
    input  logic              src_irq_en,
    input  logic              glob_irq_en,
    input  logic [PRIO_W-1:0] prio_level,
    output logic              irq_req
);

    cfg_t             cfg_q;
    logic [CNT_W-1:0] limit_q;
    logic             cfg_wr;
    logic             limit_wr;
    logic             cfg_run;
    logic             step_go;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] ticks;
    logic [CNT_W-1:0] count_q;
    logic             wrapped;

    pst_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .cfg_q    (cfg_q),
        .limit_q  (limit_q),
        .cfg_wr   (cfg_wr),
        .limit_wr (limit_wr)
    );

    assign cfg_run = cfg_q.run;
    // any register write in the same cycle discards the step
    assign step_go = cfg_run && step_valid && !wr_en;

    pst_prescale #(.TABLE(TABLE)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clear   (cfg_wr),
        .advance (step_go),
        .sel     (cfg_q.sel),
        .cycles  (step_cycles),
        .acc_q   (acc_q),
        .ticks   (ticks)
    );

    pst_count u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (cfg_wr || limit_wr),
        .advance (step_go),
        .limit   (limit_q),
        .ticks   (ticks),
        .count_q (count_q),
        .wrapped (wrapped)
    );

    pst_irq_gate #(.PRIO_GATE(PRIO_GATE), .PRIO_CEIL(PRIO_CEIL)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .wrapped (wrapped),
        .src_en  (src_irq_en),
        .glob_en (glob_irq_en),
        .prio    (prio_level),
        .irq_q   (irq_req)
    );

    always_comb begin
        if (reg_sel_e'(rd_sel) == REG_CFG)
            rd_data = {cfg_q.run, {(CNT_W-1-SEL_W){1'b0}}, cfg_q.sel};
        else
            rd_data = count_q;
    end

endmodule

// File: rtl/pscmp_timer_chk.sv
module pscmp_timer_chk
    import pst_pkg::*;
#(
    parameter bit PRIO_GATE = 1'b1,
    parameter int PRIO_CEIL = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_sel,
    input logic              step_valid,
    input logic              src_irq_en,
    input logic              glob_irq_en,
    input logic [PRIO_W-1:0] prio_level,
    input logic              irq_req,
    input logic              cfg_run,
    input logic [CNT_W-1:0]  count_q,
    input logic [CNT_W-1:0]  limit_q,
    input logic [ACC_W-1:0]  acc_q
);

    assert_cfg_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> (count_q == '0 && acc_q == '0));

    assert_limit_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel) |=> (count_q == '0));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_run && !wr_en) |=> ($stable(count_q) && !irq_req));

    assert_idle_acc_R5: assert property (@(posedge clk) disable iff (rst)
        !cfg_run |-> (acc_q == '0));

    assert_count_below_limit_R7: assert property (@(posedge clk) disable iff (rst)
        (limit_q == '0) ? (count_q == '0) : (count_q < limit_q));

    assert_irq_enables_R8: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> $past(step_valid && src_irq_en && glob_irq_en && cfg_run));

    assert_irq_prio_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_req && PRIO_GATE) |-> ($past(prio_level) < PRIO_W'(PRIO_CEIL)));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !irq_req);

endmodule

bind pscmp_timer pscmp_timer_chk #(.PRIO_GATE(PRIO_GATE), .PRIO_CEIL(PRIO_CEIL)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .step_valid  (step_valid),
    .src_irq_en  (src_irq_en),
    .glob_irq_en (glob_irq_en),
    .prio_level  (prio_level),
    .irq_req     (irq_req),
    .cfg_run     (cfg_run),
    .count_q     (count_q),
    .limit_q     (limit_q),
    .acc_q       (acc_q)
);

// File: tb/pscmp_timer_tb_top.sv
`timescale 1ns/1ps
module pscmp_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data, rd_alt;
    logic       step_valid = 1'b0;
    logic [7:0] step_cycles = '0;
    logic       src_irq_en = 1'b0;
    logic       glob_irq_en = 1'b0;
    logic [2:0] prio_level = '0;
    logic       irq_req, irq_alt;

    always #10 clk = ~clk;

    pscmp_timer #(.PRIO_GATE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .step_valid(step_valid),
        .step_cycles(step_cycles), .src_irq_en(src_irq_en),
        .glob_irq_en(glob_irq_en), .prio_level(prio_level), .irq_req(irq_req));

    pscmp_timer #(.PRIO_GATE(1'b0)) dut_alt_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_alt), .step_valid(step_valid),
        .step_cycles(step_cycles), .src_irq_en(src_irq_en),
        .glob_irq_en(glob_irq_en), .prio_level(prio_level), .irq_req(irq_alt));

    int n_chk = 0;
    int n_err = 0;
    int cyc_cnt = 0;

    // reference state
    bit m_run = 0;
    int m_sel = 0;
    int m_cmp = 0;
    int m_acc = 0;
    int m_cnt = 0;
    int lfsr  = 32'h1d2c_3b4a;

    function automatic int period_of(input int s);
        return (2 << s) / 2;
    endfunction

    function automatic int next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >>> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr & 32'h7fff_ffff;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_wr(input bit sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (!sel) begin
            m_run = d[7]; m_sel = int'(d[2:0]); m_acc = 0; m_cnt = 0;
        end else begin
            m_cmp = int'(d); m_cnt = 0;
        end
    endtask

    // applies one step, then checks count and both request outputs
    task automatic do_step(input int cyc, input bit se, input bit ge,
                           input int pr, input string req);
        bit wr_any;
        step_valid = 1'b1; step_cycles = 8'(cyc);
        src_irq_en = se; glob_irq_en = ge; prio_level = 3'(pr);
        @(negedge clk);
        step_valid = 1'b0;
        wr_any = 0;
        if (m_run) begin
            m_acc += cyc;
            while (m_acc >= period_of(m_sel)) begin
                m_acc -= period_of(m_sel);
                m_cnt++;
                if (m_cnt >= m_cmp) begin
                    m_cnt = 0;
                    wr_any = 1;
                end
            end
        end
        rd_sel = 1'b1;
        #1;
        check({req, " count"}, int'(rd_data), m_cnt);
        check({req, " alt count"}, int'(rd_alt), m_cnt);
        check({req, " irq R8/R9"}, int'(irq_req), int'(wr_any && se && ge && pr < 4));
        check({req, " alt irq R9"}, int'(irq_alt), int'(wr_any && se && ge));
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 150000) begin
                n_chk++; n_err++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 150000);
                $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    initial begin : stim
        int cmps[6] = '{0, 1, 3, 7, 200, 255};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_sel = 1'b0; #1;
        check("R1 cfg", int'(rd_data), 0);
        rd_sel = 1'b1; #1;
        check("R1 count", int'(rd_data), 0);
        check("R1 irq", int'(irq_req), 0);

        // R2 configuration readback
        do_wr(1'b0, 8'hFF);
        rd_sel = 1'b0; #1;
        check("R2 cfg ff", int'(rd_data), 8'h87);
        do_wr(1'b0, 8'h05);
        #1;
        check("R2 cfg 05", int'(rd_data), 8'h05);

        // R4 limit write clears count, read shows count not limit
        do_wr(1'b0, 8'h80);
        do_wr(1'b1, 8'd50);
        do_step(7, 0, 0, 0, "R6 pre");
        do_wr(1'b1, 8'd40);
        rd_sel = 1'b1; #1;
        check("R4 cleared count", int'(rd_data), 0);

        // R6 R7 R8 R9 sweep over select and compare values
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 6; c++) begin
                do_wr(1'b0, 8'h80 | 8'(s));
                do_wr(1'b1, 8'(cmps[c]));
                for (int k = 0; k < 24; k++) begin
                    int r;
                    r = next_rand();
                    do_step(r & 255, ((r >> 8) & 3) != 0, ((r >> 10) & 3) != 0,
                            (r >> 12) & 7, "R6/R7 sweep");
                end
            end
        end

        // R3 configuration write drops the collected remainder
        do_wr(1'b0, 8'h87);
        do_wr(1'b1, 8'd255);
        do_step(100, 1, 1, 0, "R3 first");
        do_wr(1'b0, 8'h87);
        do_step(100, 1, 1, 0, "R3 after clear");
        check("R3 explicit", int'(rd_data), 0);

        // R5 stopped timer ignores steps
        do_wr(1'b0, 8'h00);
        do_wr(1'b1, 8'd0);
        do_step(200, 1, 1, 0, "R5 idle");
        check("R5 explicit irq", int'(irq_alt), 0);
        do_wr(1'b0, 8'h80);
        do_step(1, 1, 1, 0, "R7 limit zero");
        check("R7 explicit irq", int'(irq_req), 1);

        // R10 write in the same cycle as a step discards the step
        do_wr(1'b0, 8'h82);
        do_wr(1'b1, 8'd100);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'd100;
        step_valid = 1'b1; step_cycles = 8'd3;
        @(negedge clk);
        wr_en = 1'b0; step_valid = 1'b0;
        m_cmp = 100; m_cnt = 0;
        #1;
        check("R10 irq", int'(irq_req), 0);
        do_step(1, 1, 1, 0, "R10 no carry");
        check("R10 explicit", int'(rd_data), 0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule